// File: doc/BRIEF.md
# Zero-Crossing Half-Pulse Transient Controller

This block is the digital pulse-width modulator of a buck converter that settles load transients with little output deviation. In steady state it runs a fixed-period, trailing-edge PWM. The duty count comes from an outer voltage compensator and is captured at the start of each period. The block also watches a one-bit comparator flag that gives the sign of the output capacitor current. The flag passes through a synchronizer. When the synchronized sign changes, the block drops the running period and drives one half-pulse. After a rising crossing the high-side switch stays on for half of the on-time. After a falling crossing it stays off for half of the off-time.

The half-pulse lengths come only from the duty count that was captured before the transient. No inductor or capacitor value is needed. Each half-pulse is timed by a timer of its own. A crossing in the opposite direction that arrives while a half-pulse is running cancels that half-pulse and starts the other one. Every exit from a half-pulse starts a fresh PWM period.

The control state machine has four states, each with a distinct output behaviour:
- `ST_IDLE`: gate off.
- `ST_RUN`: trailing-edge PWM.
- `ST_ON_HOLD`: gate forced on.
- `ST_OFF_HOLD`: gate forced off.

Its transitions are:
- `T_ENABLE`: from `ST_IDLE` to `ST_RUN`.
- `T_WRAP`: from `ST_RUN` back to `ST_RUN` at the end of a period.
- `T_RISE`: from `ST_RUN` to `ST_ON_HOLD`.
- `T_FALL`: from `ST_RUN` to `ST_OFF_HOLD`.
- `T_ON_DONE`: from `ST_ON_HOLD` to `ST_RUN`.
- `T_OFF_DONE`: from `ST_OFF_HOLD` to `ST_RUN`.
- `T_ON_TO_OFF`: from `ST_ON_HOLD` to `ST_OFF_HOLD`.
- `T_OFF_TO_ON`: from `ST_OFF_HOLD` to `ST_ON_HOLD`.
- `T_DISABLE`: from any state to `ST_IDLE`.

Top module: `zc_halfpulse_ctrl`

## Requirements
- R1: While `rst` is high, and on every clock after a cycle in which `enable` was low, `gate_hi` is 0.
- R2: `gate_lo` is always the complement of `gate_hi`.
- R3: In steady running, the period is 2^CNT_W clocks. `gate_hi` is 1 for the first D clocks of each period and 0 for the rest, where D is the `duty_cmd` value captured at the period start. With the default CNT_W of 10 the period is 1024 clocks.
- R4: A change of `duty_cmd` in the middle of a period does not affect that period. It takes effect from the next period start.
- R5: A 0-to-1 change of `cap_i_sign` while running gives a forced-on half-pulse of max(D>>1, 1) clocks. The half-pulse is first visible after the third rising clock edge following the change. D is the duty count captured before the crossing, and the shift truncates.
- R6: A 1-to-0 change of `cap_i_sign` while running gives a forced-off half-pulse of max((2^CNT_W − D)>>1, 1) clocks, with the same latency as R5.
- R7: When a half-pulse ends, a new period starts at position 0 with a freshly captured `duty_cmd`.
- R8: The captured duty count is frozen while a half-pulse runs. A change of `duty_cmd` during a half-pulse does not change the length of a half-pulse started later within the same transient.
- R9: An opposite crossing during a half-pulse ends it and starts the other half-pulse, whose length is taken from the frozen duty count. At most one half-pulse timer is busy at any time.
- R10: Raising `enable` starts a period at position 0, with `duty_cmd` captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable; low forces the gate off |
| duty_cmd | input | CNT_W | Duty count from the voltage compensator |
| cap_i_sign | input | 1 | Asynchronous sign of the capacitor current (1 = charging) |
| gate_hi | output | 1 | High-side switch command |
| gate_lo | output | 1 | Low-side switch command, complement of `gate_hi` |

## Verification
The bound checker checks the following on every cycle:
- the gate is off after a disabled cycle;
- the period position advances by one while running;
- every return to running starts at position 0;
- the captured duty count holds still from one half-pulse cycle to the next;
- at most one half-pulse timer is busy;
- a forced half-pulse has the right polarity on its first cycle.

Only the bench scenarios can show the exact half-pulse lengths and the truncation of odd counts. The same applies to the three-edge latency after a sign change, to a cancelled half-pulse taking its length from the frozen duty count, and to a mid-period duty change waiting for the next period.

// File: rtl/zc_halfpulse_pkg.sv
package zc_halfpulse_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RUN      = 2'd1,
        ST_ON_HOLD  = 2'd2,
        ST_OFF_HOLD = 2'd3
    } zc_state_e;

    localparam int HP_ON    = 0;
    localparam int HP_OFF   = 1;
    localparam int HP_COUNT = 2;
endpackage

// File: rtl/zc_sign_sync.sv
module zc_sign_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    // sh[0..STAGES-1] form the synchronizer, sh[STAGES] holds the previous value
    logic [STAGES:0] sh;

    genvar i;
    generate
        for (i = 0; i <= STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sh[0] <= 1'b0;
                    else     sh[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sh[i] <= 1'b0;
                    else     sh[i] <= sh[i-1];
                end
            end
        end
    endgenerate

    always_comb begin
        rise = sh[STAGES-1] & ~sh[STAGES];
        fall = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/zc_half_timer.sv
module zc_half_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         abort,
    input  logic [W-1:0] ref_len,
    output logic         busy,
    output logic         last
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= (ref_len == '0) ? W'(1) : ref_len;
        end else if (abort) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - W'(1);
        end
    end

    always_comb begin
        busy = (left_q != '0);
        last = (left_q == W'(1));
    end
endmodule

// File: rtl/zc_halfpulse_ctrl.sv
module zc_halfpulse_ctrl
    import zc_halfpulse_pkg::*;
#(
    parameter int CNT_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic             cap_i_sign,
    output logic             gate_hi,
    output logic             gate_lo
);
    localparam logic [CNT_W-1:0] LAST_POS = {CNT_W{1'b1}};
    localparam logic [CNT_W:0]   PERIOD   = {1'b1, {CNT_W{1'b0}}};

    zc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] duty_q;
    logic             sign_rise, sign_fall;
    logic             period_start;

    logic [HP_COUNT-1:0] hp_start, hp_abort, hp_busy, hp_last;
    logic [CNT_W-1:0]    hp_ref [HP_COUNT];
    logic [CNT_W:0]      off_span;

    zc_sign_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_i_sign),
        .rise (sign_rise),
        .fall (sign_fall)
    );

    // half-pulse references from the frozen duty count, truncating shift
    always_comb begin
        off_span        = PERIOD - {1'b0, duty_q};
        hp_ref[HP_ON]   = duty_q >> 1;
        hp_ref[HP_OFF]  = CNT_W'(off_span >> 1);
    end

    genvar g;
    generate
        for (g = 0; g < HP_COUNT; g++) begin : g_hp
            zc_half_timer #(.W(CNT_W)) u_timer (
                .clk     (clk),
                .rst     (rst),
                .start   (hp_start[g]),
                .abort   (hp_abort[g]),
                .ref_len (hp_ref[g]),
                .busy    (hp_busy[g]),
                .last    (hp_last[g])
            );
        end
    endgenerate

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;                               // T_DISABLE
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_RUN;               // T_ENABLE
                ST_RUN: begin
                    if (sign_rise)      state_d = ST_ON_HOLD;  // T_RISE
                    else if (sign_fall) state_d = ST_OFF_HOLD; // T_FALL
                    else                state_d = ST_RUN;      // T_WRAP / count
                end
                ST_ON_HOLD: begin
                    if (sign_fall)             state_d = ST_OFF_HOLD; // T_ON_TO_OFF
                    else if (hp_last[HP_ON])   state_d = ST_RUN;      // T_ON_DONE
                end
                ST_OFF_HOLD: begin
                    if (sign_rise)             state_d = ST_ON_HOLD;  // T_OFF_TO_ON
                    else if (hp_last[HP_OFF])  state_d = ST_RUN;      // T_OFF_DONE
                end
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // strobes derived from the transition
    always_comb begin
        hp_start[HP_ON]  = (state_d == ST_ON_HOLD)  && (state_q != ST_ON_HOLD);
        hp_start[HP_OFF] = (state_d == ST_OFF_HOLD) && (state_q != ST_OFF_HOLD);
        hp_abort[HP_ON]  = hp_start[HP_OFF] | ~enable;
        hp_abort[HP_OFF] = hp_start[HP_ON]  | ~enable;
        period_start     = (state_d == ST_RUN) &&
                           ((state_q != ST_RUN) || (cnt_q == LAST_POS));
    end

    // state register, period counter and duty capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            duty_q  <= '0;
        end else begin
            state_q <= state_d;
            if (period_start) begin
                cnt_q  <= '0;
                duty_q <= duty_cmd;
            end else if (state_q == ST_RUN && state_d == ST_RUN) begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        unique case (state_q)
            ST_IDLE:     gate_hi = 1'b0;
            ST_RUN:      gate_hi = (cnt_q < duty_q);
            ST_ON_HOLD:  gate_hi = 1'b1;
            ST_OFF_HOLD: gate_hi = 1'b0;
            default:     gate_hi = 1'b0;
        endcase
        gate_lo = ~gate_hi;
    end
endmodule

// File: rtl/zc_halfpulse_ctrl_chk.sv
module zc_halfpulse_ctrl_chk
    import zc_halfpulse_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             gate_hi,
    input zc_state_e        state_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] duty_q,
    input logic [1:0]       hp_busy,
    input logic [1:0]       hp_start
);
    assert_idle_gate_off_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !gate_hi);

    assert_run_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && $past(enable))
            |-> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));

    assert_period_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> cnt_q == '0);

    assert_duty_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ON_HOLD || state_q == ST_OFF_HOLD) &&
         ($past(state_q) == ST_ON_HOLD || $past(state_q) == ST_OFF_HOLD))
            |-> $stable(duty_q));

    assert_single_timer_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hp_busy));

    assert_on_pulse_high_R5: assert property (@(posedge clk) disable iff (rst)
        hp_start[HP_ON] |=> gate_hi);

    assert_off_pulse_low_R6: assert property (@(posedge clk) disable iff (rst)
        hp_start[HP_OFF] |=> !gate_hi);
endmodule

bind zc_halfpulse_ctrl zc_halfpulse_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .gate_hi  (gate_hi),
    .state_q  (state_q),
    .cnt_q    (cnt_q),
    .duty_q   (duty_q),
    .hp_busy  (hp_busy),
    .hp_start (hp_start)
);

// File: tb/zc_halfpulse_ctrl_tb.sv
module zc_halfpulse_ctrl_tb;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b0;
    logic [CNT_W-1:0] duty_cmd = '0;
    logic             cap_i_sign = 1'b0;
    logic             gate_hi, gate_lo;

    int n_cmp = 0;
    int n_bad = 0;
    logic  exp_q [$];
    string req_q [$];

    always #10 clk = ~clk;

    zc_halfpulse_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .duty_cmd   (duty_cmd),
        .cap_i_sign (cap_i_sign),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo)
    );

    // driver: one expected gate value per clock, for the value after this edge
    task automatic cyc(input logic hi, input string req);
        @(posedge clk);
        #1;
        exp_q.push_back(hi);
        req_q.push_back(req);
    endtask

    task automatic run(input int n, input logic hi, input string req);
        for (int k = 0; k < n; k++) cyc(hi, req);
    endtask

    // monitor: pops and compares away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic  e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            n_cmp++;
            if (gate_hi !== e) begin
                n_bad++;
                $display("FAIL %s gate_hi actual=%b expected=%b t=%0t", r, gate_hi, e, $time);
            end
            n_cmp++;
            if (gate_lo !== ~e) begin
                n_bad++;
                $display("FAIL R2 gate_lo actual=%b expected=%b t=%0t", gate_lo, ~e, $time);
            end
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset and disabled
        run(4, 1'b0, "R1");
        rst = 1'b0;
        run(5, 1'b0, "R1");

        // R10 / R3: enable starts a period with duty 300
        duty_cmd = 10'd300;
        enable = 1'b1;
        run(300, 1'b1, "R10");
        run(724, 1'b0, "R3");
        // R4: change mid-period, old duty holds this period
        run(50, 1'b1, "R3");
        duty_cmd = 10'd100;
        run(250, 1'b1, "R4");
        run(724, 1'b0, "R4");
        run(100, 1'b1, "R4");
        duty_cmd = 10'd601;
        run(924, 1'b0, "R4");

        // R5: rising crossing with odd duty 601 -> 300-clock on pulse
        run(200, 1'b1, "R3");
        cap_i_sign = 1'b1;
        run(2, 1'b1, "R5");
        run(10, 1'b1, "R5");
        duty_cmd = 10'd801;
        run(290, 1'b1, "R5");
        // R7: new period with 801, then R6 falling crossing -> 111-clock off pulse
        run(100, 1'b1, "R7");
        cap_i_sign = 1'b0;
        run(2, 1'b1, "R6");
        run(10, 1'b0, "R6");
        duty_cmd = 10'd256;
        run(101, 1'b0, "R6");
        run(256, 1'b1, "R7");
        run(768, 1'b0, "R7");

        // R9 / R8: on pulse (128) cancelled by falling crossing; off uses frozen 256 -> 384
        run(50, 1'b1, "R3");
        cap_i_sign = 1'b1;
        run(2, 1'b1, "R5");
        run(20, 1'b1, "R5");
        duty_cmd = 10'd900;
        cap_i_sign = 1'b0;
        run(2, 1'b1, "R9");
        run(384, 1'b0, "R8");
        run(900, 1'b1, "R7");
        duty_cmd = 10'd1;
        run(124, 1'b0, "R3");

        // R5 minimum: duty 1 -> half is 0 -> one-clock pulse
        run(1, 1'b1, "R3");
        duty_cmd = 10'd0;
        run(10, 1'b0, "R3");
        cap_i_sign = 1'b1;
        run(2, 1'b0, "R5");
        run(1, 1'b1, "R5");
        run(20, 1'b0, "R7");
        cap_i_sign = 1'b0;
        duty_cmd = 10'd500;
        run(2, 1'b0, "R6");
        run(512, 1'b0, "R6");
        run(100, 1'b1, "R7");

        // R1 / R10: disable mid-period, then re-enable
        enable = 1'b0;
        run(5, 1'b0, "R1");
        enable = 1'b1;
        run(500, 1'b1, "R10");
        run(10, 1'b0, "R10");

        @(negedge clk);
        #1;
        finish_run();
    end
endmodule